// File: doc/BRIEF.md
# Power-Fail Write-Protect Controller

This block sits between a host and a battery-backed byte-wide static RAM. It watches two comparator flags: the supply has dropped below the power-fail threshold, and the supply has dropped below the battery switchover threshold. When the supply is good, it passes the host's active-low chip enable, output enable and write enable to the array unchanged. It also drives the data-bus output enable for reads.

When the supply fails, the block deselects and write-protects the array. A cycle that is already running (chip enable held low) may finish, but only for a bounded number of clock cycles. While the supply sits below the switchover threshold, the power select points at the battery. When the supply comes back, protection stays on for a fixed recovery time before normal access resumes. Both comparator flags are asynchronous and pass through a two-flop synchroniser. After reset the block is protected and runs one full recovery period before the array becomes usable.

Top module: `pwrfail_guard`

## Requirements
- R1: When the block is in normal operation, memCeN, memOeN and memWeN follow hostCeN, hostOeN and hostWeN combinationally, and writeProtect is 0.
- R2: dqDrive is 1 only when access is allowed, hostCeN is 0, hostOeN is 0 and hostWeN is 1. Otherwise it is 0.
- R3: If the synchronised power-fail flag is seen in normal operation while hostCeN is 1, protection is asserted on the next edge. Measured from the first clock edge that samples the raw flag, writeProtect rises after the third edge.
- R4: If hostCeN is 0 when the power fail is seen, that access keeps passing to the array. It stops when hostCeN rises, or after WP_CYCLES cycles, whichever comes first. Protection then follows on the next edge.
- R5: While protected, memCeN, memOeN and memWeN are all 1, dqDrive is 0 and writeProtect is 1, whatever the host strobes do.
- R6: After the power-fail flag clears, writeProtect falls exactly 3 + ER_CYCLES edges after the first edge that samples the cleared flag. If the flag returns during recovery, the block goes back to protected and the full recovery time restarts.
- R7: useBattery rises 3 edges after the switchover flag is raised and falls 3 edges after it clears. While useBattery is 1, the block stays protected.
- R8: After reset, writeProtect is 1 and useBattery is 0. With both flags low, writeProtect falls 3 + ER_CYCLES edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low asynchronous reset |
| belowPfAsync | input | 1 | Comparator: supply below power-fail threshold (asynchronous) |
| belowSoAsync | input | 1 | Comparator: supply below battery switchover threshold (asynchronous) |
| hostCeN | input | 1 | Host chip enable, active low |
| hostOeN | input | 1 | Host output enable, active low |
| hostWeN | input | 1 | Host write enable, active low |
| memCeN | output | 1 | Gated chip enable to the array |
| memOeN | output | 1 | Gated output enable to the array |
| memWeN | output | 1 | Gated write enable to the array |
| dqDrive | output | 1 | Data-bus output drive enable (1 = drive read data) |
| useBattery | output | 1 | Power select: 1 = internal battery, 0 = external supply |
| writeProtect | output | 1 | Array deselected and write-protected |

## Verification
A state machine stuck in or wrongly leaving protection appears at the ports at once. The gated strobes stop tracking the host strobes, or keep tracking them, in the same cycle that writeProtect changes. An off-by-one in either timer moves the edge of writeProtect by exactly one cycle, so the bench samples both sides of each expected edge. A bad switchover path shows as useBattery changing on the wrong edge or changing while the block is not protected.

// File: rtl/pfwp_pkg.sv
package pfwp_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL,
    ST_PF_PENDING,
    ST_PROTECTED,
    ST_BATTERY,
    ST_RECOVERY
  } guardState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic passAccess;
    logic selBattery;
  } guardCtrl_t;

endpackage

// File: rtl/pfwp_sync.sv
module pfwp_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[g] <= RESET_VAL;
        else if (g == 0) chain[g] <= asyncIn;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/pfwp_control.sv
module pfwp_control
  import pfwp_pkg::*;
#(
  parameter int WP_CYCLES = 8,
  parameter int ER_CYCLES = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pfSync,
  input  logic       soSync,
  input  logic       hostCeN,
  output guardCtrl_t ctrl
);
  localparam int MAX_CYC = (WP_CYCLES > ER_CYCLES) ? WP_CYCLES : ER_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  guardState_t state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    unique case (state)
      ST_NORMAL: begin
        if (pfSync) begin
          if (!hostCeN) begin
            stateNext = ST_PF_PENDING;
            cntNext   = CNT_W'(WP_CYCLES - 1);
          end else begin
            stateNext = ST_PROTECTED;
          end
        end
      end
      ST_PF_PENDING: begin
        if (hostCeN || cnt == '0) stateNext = ST_PROTECTED;
        else cntNext = cnt - 1'b1;
      end
      ST_PROTECTED: begin
        if (!pfSync) begin
          stateNext = ST_RECOVERY;
          cntNext   = CNT_W'(ER_CYCLES - 1);
        end
      end
      ST_BATTERY: begin
        if (!soSync) stateNext = ST_PROTECTED;
      end
      ST_RECOVERY: begin
        if (pfSync) stateNext = ST_PROTECTED;
        else if (cnt == '0) stateNext = ST_NORMAL;
        else cntNext = cnt - 1'b1;
      end
      default: stateNext = ST_PROTECTED;
    endcase
    if (soSync) stateNext = ST_BATTERY;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_PROTECTED;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  assign ctrl.passAccess = (state == ST_NORMAL) || (state == ST_PF_PENDING);
  assign ctrl.selBattery = (state == ST_BATTERY);

  // Assertion-side age counters
  logic [CNT_W:0] pendAge, recAge;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendAge <= '0;
      recAge  <= '0;
    end else begin
      pendAge <= (state == ST_PF_PENDING) ? pendAge + 1'b1 : '0;
      recAge  <= (state == ST_RECOVERY)   ? recAge + 1'b1  : '0;
    end
  end

  a_r3_idle_protect: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NORMAL && pfSync && hostCeN && !soSync) |=> state == ST_PROTECTED);

  a_r4_window_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PF_PENDING) |-> (pendAge < (CNT_W+1)'(WP_CYCLES)));

  a_r4_access_end: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PF_PENDING && hostCeN && !soSync) |=> state == ST_PROTECTED);

  a_r6_recovery_length: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NORMAL && $past(state) != ST_NORMAL) |->
      ($past(state) == ST_RECOVERY && recAge == (CNT_W+1)'(ER_CYCLES)));

  a_r7_battery_follow: assert property (@(posedge clk) disable iff (!rstN)
    soSync |=> state == ST_BATTERY);
endmodule

// File: rtl/pfwp_gate.sv
module pfwp_gate
  import pfwp_pkg::*;
(
  input  guardCtrl_t ctrl,
  input  logic       hostCeN,
  input  logic       hostOeN,
  input  logic       hostWeN,
  output logic       memCeN,
  output logic       memOeN,
  output logic       memWeN,
  output logic       dqDrive,
  output logic       useBattery,
  output logic       writeProtect
);
  logic block;
  assign block        = ~ctrl.passAccess;
  assign memCeN       = hostCeN | block;
  assign memOeN       = hostOeN | block;
  assign memWeN       = hostWeN | block;
  assign dqDrive      = ~memCeN & ~memOeN & hostWeN;
  assign useBattery   = ctrl.selBattery;
  assign writeProtect = block;

  always_comb begin
    if (useBattery) a_r7_battery_protected: assert (writeProtect);
  end
endmodule

// File: rtl/pwrfail_guard.sv
module pwrfail_guard
  import pfwp_pkg::*;
#(
  parameter int WP_CYCLES   = 8,
  parameter int ER_CYCLES   = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic belowPfAsync,
  input  logic belowSoAsync,
  input  logic hostCeN,
  input  logic hostOeN,
  input  logic hostWeN,
  output logic memCeN,
  output logic memOeN,
  output logic memWeN,
  output logic dqDrive,
  output logic useBattery,
  output logic writeProtect
);
  logic pfSync, soSync;
  guardCtrl_t ctrl;

  pfwp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_pfSync (
    .clk(clk), .rstN(rstN), .asyncIn(belowPfAsync), .syncOut(pfSync));

  pfwp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) i_soSync (
    .clk(clk), .rstN(rstN), .asyncIn(belowSoAsync), .syncOut(soSync));

  pfwp_control #(.WP_CYCLES(WP_CYCLES), .ER_CYCLES(ER_CYCLES)) i_control (
    .clk(clk), .rstN(rstN), .pfSync(pfSync), .soSync(soSync),
    .hostCeN(hostCeN), .ctrl(ctrl));

  pfwp_gate i_gate (
    .ctrl(ctrl), .hostCeN(hostCeN), .hostOeN(hostOeN), .hostWeN(hostWeN),
    .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN), .dqDrive(dqDrive),
    .useBattery(useBattery), .writeProtect(writeProtect));
endmodule

// File: tb/test_pwrfail_guard.sv
module test_pwrfail_guard;
  localparam int CLK_PERIOD = 10;
  localparam int WP = 8;
  localparam int ER = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic belowPfAsync = 1'b0, belowSoAsync = 1'b0;
  logic hostCeN = 1'b1, hostOeN = 1'b1, hostWeN = 1'b1;
  logic memCeN, memOeN, memWeN, dqDrive, useBattery, writeProtect;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrfail_guard #(.WP_CYCLES(WP), .ER_CYCLES(ER)) i_pwrfail_guard (
    .clk(clk), .rstN(rstN), .belowPfAsync(belowPfAsync), .belowSoAsync(belowSoAsync),
    .hostCeN(hostCeN), .hostOeN(hostOeN), .hostWeN(hostWeN),
    .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN), .dqDrive(dqDrive),
    .useBattery(useBattery), .writeProtect(writeProtect));

  // Expected {memCeN, memOeN, memWeN, dqDrive}
  function automatic logic [3:0] expPins(input logic pass, input logic ce, input logic oe, input logic we);
    logic c, o, w;
    c = ce | ~pass; o = oe | ~pass; w = we | ~pass;
    return {c, o, w, (~c & ~o & we)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic checkPins(input string req, input logic pass);
    check(req, {28'd0, memCeN, memOeN, memWeN, dqDrive},
          {28'd0, expPins(pass, hostCeN, hostOeN, hostWeN)});
  endtask

  task automatic randomStrobes(input string req, input logic pass, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      {hostCeN, hostOeN, hostWeN} = 3'($urandom);
      #1;
      checkPins(req, pass);
      check(req, {31'd0, writeProtect}, {31'd0, ~pass});
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    step(3);
    // R8: reset state
    check("R8", {30'd0, writeProtect, useBattery}, 32'b10);
    @(negedge clk); rstN = 1'b1; #1;
    step(2 + ER);
    check("R8", {31'd0, writeProtect}, 32'd1);
    step(1);
    check("R8", {31'd0, writeProtect}, 32'd0);

    // R1/R2: normal passthrough under random strobes
    randomStrobes("R1", 1'b1, 200);
    hostCeN = 1'b0; hostOeN = 1'b0; hostWeN = 1'b1; #1;
    check("R2", {31'd0, dqDrive}, 32'd1);
    hostWeN = 1'b0; #1;
    check("R2", {31'd0, dqDrive}, 32'd0);

    // R3: power fail with no access
    @(negedge clk); hostCeN = 1'b1; hostWeN = 1'b1; belowPfAsync = 1'b1; #1;
    step(2);
    check("R3", {31'd0, writeProtect}, 32'd0);
    step(1);
    check("R3", {31'd0, writeProtect}, 32'd1);

    // R5: everything blocked while protected
    randomStrobes("R5", 1'b0, 100);

    // R6: recovery timing
    @(negedge clk); hostCeN = 1'b1; belowPfAsync = 1'b0; #1;
    step(2 + ER);
    check("R6", {31'd0, writeProtect}, 32'd1);
    step(1);
    check("R6", {31'd0, writeProtect}, 32'd0);

    // R4: access held through full window
    @(negedge clk); hostCeN = 1'b0; hostWeN = 1'b0; hostOeN = 1'b1; belowPfAsync = 1'b1; #1;
    step(3);
    check("R4", {30'd0, writeProtect, memWeN}, 32'b00);
    step(WP - 1);
    check("R4", {30'd0, writeProtect, memWeN}, 32'b00);
    step(1);
    check("R4", {30'd0, writeProtect, memWeN}, 32'b11);

    // back to normal
    @(negedge clk); hostCeN = 1'b1; hostWeN = 1'b1; belowPfAsync = 1'b0; #1;
    step(3 + ER);
    check("R6", {31'd0, writeProtect}, 32'd0);

    // R4: access ends early
    @(negedge clk); hostCeN = 1'b0; hostWeN = 1'b0; belowPfAsync = 1'b1; #1;
    step(3);
    check("R4", {31'd0, writeProtect}, 32'd0);
    hostCeN = 1'b1; hostWeN = 1'b1; #1;
    step(1);
    check("R4", {31'd0, writeProtect}, 32'd1);
    hostCeN = 1'b0; hostWeN = 1'b0; #1;
    check("R4", {31'd0, memWeN}, 32'd1);

    // R7: battery switchover
    @(negedge clk); hostCeN = 1'b1; hostWeN = 1'b1; belowSoAsync = 1'b1; #1;
    step(2);
    check("R7", {31'd0, useBattery}, 32'd0);
    step(1);
    check("R7", {30'd0, useBattery, writeProtect}, 32'b11);
    randomStrobes("R5", 1'b0, 20);
    @(negedge clk); belowSoAsync = 1'b0; #1;
    step(2);
    check("R7", {31'd0, useBattery}, 32'd1);
    step(1);
    check("R7", {30'd0, useBattery, writeProtect}, 32'b01);

    // R6: fail again during recovery restarts the full wait
    @(negedge clk); belowPfAsync = 1'b0; #1;
    step(3 + ER/2);
    belowPfAsync = 1'b1;
    step(3 + ER);
    check("R6", {31'd0, writeProtect}, 32'd1);
    @(negedge clk); belowPfAsync = 1'b0; #1;
    step(2 + ER);
    check("R6", {31'd0, writeProtect}, 32'd1);
    step(1);
    check("R6", {31'd0, writeProtect}, 32'd0);
    randomStrobes("R1", 1'b1, 50);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule